// File: doc/BRIEF.md
# I2C General Call Decoder

This block sits beside the target side of an I2C controller and watches the first two bytes that arrive after each START. A first byte of 0x00 or 0x01 marks a general call. The byte after it is decoded as a command or as a hardware caller address. Bus timing, shifting and acknowledge driving are done elsewhere. This block only gives the byte-level verdicts: whether the byte just received should be acknowledged, a sticky general-call interrupt with a 2-bit identifier, and a one-cycle interface reset request.

The host shifter pulses `byte_valid` with the received byte on `byte_data`. The acknowledge decision appears on `ack_en` on the next clock and stays there until the next byte, START or STOP. Firmware clears the interrupt by writing one to `irq_clr`. The identifier tells it which kind of call arrived.

Top module: `gc_decoder`

## Requirements
- R1: After reset, `ack_en`, `gc_irq`, `gc_id` and `iface_rst` are all 0.
- R2: With `gc_en` set, a first byte (the first `byte_valid` after START) of 0x00 or 0x01 drives `ack_en` to 1 on the clock after the strobe. Any other first byte, or `gc_en` clear, gives `ack_en` 0, and no later byte of that transfer is decoded.
- R3: Second byte 0x06 after first byte 0x00: `ack_en`=1, `gc_irq` is set, `gc_id`=1, and `iface_rst` is high for exactly one cycle. All of these appear on the clock after the strobe.
- R4: Second byte 0x04 after first byte 0x00: `ack_en`=1, `gc_irq` is set, `gc_id`=2, and there is no reset pulse.
- R5: Any other second byte after first byte 0x00: `ack_en`=0, `gc_id`=0, `gc_irq` is set, and there is no reset pulse.
- R6: After first byte 0x01 (hardware call), the second byte is acknowledged exactly when `hgc_en` is set.
- R7: A hardware call is recognised, giving `gc_id`=3, only when `hgc_en`, `gc_en` and `tgt_en` are all 1 and bits [7:1] of the second byte equal `alt_id`. Otherwise a hardware call gives `gc_id`=0. `gc_irq` is set in both cases.
- R8: `gc_irq` does not rise on the first byte of a general call. It rises only on the clock after the second byte.
- R9: Once set, `gc_irq` stays 1 until a cycle with `irq_clr`=1 clears it. A set in the same cycle as a clear wins.
- R10: STOP returns the decoder to idle, so bytes received before the next START give `ack_en`=0. A repeated START makes the next byte a first byte again. Third and later bytes of a transfer give `ack_en`=0.
- R11: `ack_en` changes only on the clock after a `byte_valid`, `start_det` or `stop_det`. START and STOP clear it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START seen (one cycle) |
| stop_det | input | 1 | STOP seen (one cycle) |
| byte_valid | input | 1 | Received byte strobe (one cycle) |
| byte_data | input | 8 | Received byte |
| gc_en | input | 1 | General-call enable |
| hgc_en | input | 1 | Hardware general-call enable |
| tgt_en | input | 1 | Target enable |
| alt_id | input | 7 | Alternate device ID for hardware calls |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| ack_en | output | 1 | Acknowledge verdict for the last byte |
| gc_irq | output | 1 | Sticky general-call interrupt |
| gc_id | output | 2 | General-call identifier |
| iface_rst | output | 1 | One-cycle interface reset request |

## Verification
Embedded properties check the following on every cycle:
- the reset request lasts one cycle and always comes with identifier 1 and a set interrupt;
- the interrupt holds until it is cleared and rises only after a strobe;
- `ack_en` moves only after a strobe, START or STOP, and START or STOP leave it low.

Which byte values give which verdict and identifier can only be shown by the bench's directed sequences. This covers the alternate-ID match under each enable combination and the return to idle after STOP or a repeated START.

// File: rtl/gc_decoder.sv
module gc_decoder #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] CMD_RESET = 8'h06,
  parameter logic [BYTE_W-1:0] CMD_NOTE  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              gc_en,
  input  logic              hgc_en,
  input  logic              tgt_en,
  input  logic [BYTE_W-2:0] alt_id,
  input  logic              irq_clr,
  output logic              ack_en,
  output logic              gc_irq,
  output logic [1:0]        gc_id,
  output logic              iface_rst
);
  localparam int AW = BYTE_W - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_CMD, ST_HW} st_t;
  st_t st, st_nx;

  logic is_gc_addr, hw_match, second, ack_nx;
  logic [1:0] id_nx;

  assign is_gc_addr = gc_en && (byte_data[BYTE_W-1:1] == '0);
  assign hw_match   = hgc_en && gc_en && tgt_en && (byte_data[BYTE_W-1:1] == alt_id);
  assign second     = byte_valid && !start_det && !stop_det && (st == ST_CMD || st == ST_HW);

  always_comb begin
    st_nx  = st;
    ack_nx = 1'b0;
    id_nx  = 2'd0;
    if (start_det) st_nx = ST_FIRST;
    else if (stop_det) st_nx = ST_IDLE;
    else if (byte_valid) begin
      st_nx = ST_IDLE;
      case (st)
        ST_FIRST: begin
          ack_nx = is_gc_addr;
          if (is_gc_addr) st_nx = byte_data[0] ? ST_HW : ST_CMD;
        end
        ST_CMD: begin
          ack_nx = (byte_data == CMD_RESET) || (byte_data == CMD_NOTE);
          id_nx  = (byte_data == CMD_RESET) ? 2'd1 :
                   (byte_data == CMD_NOTE)  ? 2'd2 : 2'd0;
        end
        ST_HW: begin
          ack_nx = hgc_en;
          id_nx  = hw_match ? 2'd3 : 2'd0;
        end
        default: ack_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ack_en    <= 1'b0;
      gc_irq    <= 1'b0;
      gc_id     <= 2'd0;
      iface_rst <= 1'b0;
    end else begin
      st        <= st_nx;
      iface_rst <= second && (st == ST_CMD) && (byte_data == CMD_RESET);
      if (start_det || stop_det || byte_valid) ack_en <= ack_nx;
      if (second) begin
        gc_id  <= id_nx;
        gc_irq <= 1'b1;
      end else if (irq_clr) gc_irq <= 1'b0;
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |=> !iface_rst);
  a_r3_reset_id: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |-> (gc_id == 2'd1 && gc_irq));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_irq && !irq_clr) |=> gc_irq);
  a_r8_irq_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_irq) |-> $past(byte_valid));
  a_r11_ack_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !ack_en);
  a_r11_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_en) |-> $past(byte_valid || start_det || stop_det));
endmodule

// File: tb/sim_gc_decoder.sv
module sim_gc_decoder;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic start_det = 0, stop_det = 0, byte_valid = 0, irq_clr = 0;
  logic [7:0] byte_data = 0;
  logic gc_en = 1, hgc_en = 1, tgt_en = 1;
  logic [6:0] alt_id = 7'h2A;
  logic ack_en, gc_irq, iface_rst;
  logic [1:0] gc_id;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gc_decoder u0 (.clk, .rst_n, .start_det, .stop_det, .byte_valid, .byte_data,
    .gc_en, .hgc_en, .tgt_en, .alt_id, .irq_clr, .ack_en, .gc_irq, .gc_id, .iface_rst);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start();
    start_det = 1; tick(); start_det = 0;
  endtask

  task automatic do_stop();
    stop_det = 1; tick(); stop_det = 0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_data = b; byte_valid = 1; tick(); byte_valid = 0;
  endtask

  task automatic clear_irq();
    irq_clr = 1; tick(); irq_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 ack", ack_en, 0); check("R1 irq", gc_irq, 0);
    check("R1 id", gc_id, 0); check("R1 rst", iface_rst, 0);
  endtask

  task automatic t_reset_cmd();
    do_start(); send(8'h00);
    check("R2 first ack", ack_en, 1);
    check("R8 no irq on first", gc_irq, 0);
    send(8'h06);
    check("R3 ack", ack_en, 1); check("R3 irq", gc_irq, 1);
    check("R3 id", gc_id, 1); check("R3 pulse", iface_rst, 1);
    tick(); check("R3 pulse ends", iface_rst, 0);
    send(8'h55); check("R10 third byte no ack", ack_en, 0);
    do_stop(); check("R11 stop clears", ack_en, 0);
    tick(); check("R9 irq held", gc_irq, 1);
    clear_irq(); check("R9 irq cleared", gc_irq, 0);
  endtask

  task automatic t_note_cmd();
    do_start(); send(8'h00); send(8'h04);
    check("R4 ack", ack_en, 1); check("R4 id", gc_id, 2);
    check("R4 irq", gc_irq, 1); check("R4 no rst", iface_rst, 0);
    do_stop(); clear_irq();
  endtask

  task automatic t_other_cmd();
    do_start(); send(8'h00); send(8'h07);
    check("R5 no ack", ack_en, 0); check("R5 id", gc_id, 0);
    check("R5 irq", gc_irq, 1); check("R5 no rst", iface_rst, 0);
    do_stop();
    irq_clr = 1; do_start(); irq_clr = 0;
    send(8'h00); irq_clr = 1; send(8'h04); irq_clr = 0;
    check("R9 set wins over clear", gc_irq, 1);
    do_stop(); clear_irq();
  endtask

  task automatic t_hw(input logic h, input logic g, input logic t,
                      input logic [7:0] b, input int exp_id);
    hgc_en = h; gc_en = g; tgt_en = t;
    do_start(); send(8'h01);
    check("R2 hw first ack", ack_en, g);
    if (g) begin
      send(b);
      check("R6 hw ack", ack_en, h);
      check("R7 hw id", gc_id, exp_id);
      check("R7 hw irq", gc_irq, 1);
    end
    do_stop(); clear_irq();
    hgc_en = 1; gc_en = 1; tgt_en = 1;
  endtask

  task automatic t_non_gc();
    do_start(); send(8'h42);
    check("R2 non-gc no ack", ack_en, 0);
    send(8'h06);
    check("R2 no decode after non-gc", gc_irq, 0);
    check("R2 no rst after non-gc", iface_rst, 0);
    do_stop();
  endtask

  task automatic t_idle_and_restart();
    send(8'h00); check("R10 byte after stop ignored", ack_en, 0);
    do_start(); send(8'h00); do_start();
    check("R11 start clears", ack_en, 0);
    send(8'h00); check("R10 repeated start first byte", ack_en, 1);
    send(8'h04); check("R10 second after restart", gc_id, 2);
    do_stop(); clear_irq();
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_reset_cmd();
    t_note_cmd();
    t_other_cmd();
    t_hw(1, 1, 1, {7'h2A, 1'b1}, 3);
    t_hw(1, 1, 1, {7'h2B, 1'b1}, 0);
    t_hw(1, 1, 0, {7'h2A, 1'b1}, 0);
    t_hw(0, 1, 1, {7'h2A, 1'b1}, 0);
    t_hw(1, 0, 1, {7'h2A, 1'b1}, 0);
    t_non_gc();
    gc_en = 0; do_start(); send(8'h00);
    check("R2 gc disabled no ack", ack_en, 0);
    send(8'h06); check("R2 gc disabled no irq", gc_irq, 0);
    do_stop(); gc_en = 1;
    t_idle_and_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule